// File: doc/BRIEF.md
# Serial Test Port with SRAM Boundary Wrapper

This block places a chain of boundary cells around every pin of a small SRAM (write data, read data, address, output enable and write enable) and gives a host control of that chain through a four-wire serial test port. The port has a clock, a mode-select line, a serial input and a serial output with its own output-enable. A 16-state test controller steps through capture, shift and update phases. A 2-bit instruction register chooses which data register sits between the serial input and output. It also chooses whether the boundary cells drive their held test values onto the pins.

In normal operation every cell passes its functional value straight through, and the wrapper is transparent. A host can sample the live pin values, preload test values without disturbing the pins, and then switch to external-test mode to drive the preloaded values. Used this way it can run walking-ones data tests, power-of-two address tests and fill tests on the SRAM wiring entirely over the serial link. All serial-input sampling and state changes happen on the rising test-clock edge. The serial output, the update stage and the instruction latch change on the falling edge. No clock is ever gated with a state decode; the capture, shift and update steps are clock enables taken from the registered controller state.

Top module: `bsw_sram_wrap`

## Requirements
- R1: While `rst` is high and afterwards until another instruction is loaded, the controller sits in Test-Logic-Reset and the active instruction is BYPASS. `tdo_oe` is 0 and `tdo` is 0. Every SRAM-side output equals its core-side input, and `core_rdata` equals `mem_rdata`.
- R2: Five consecutive rising edges with `tms` high bring the controller to Test-Logic-Reset from any state. Reaching that state restores BYPASS, so all pins go back to pass-through and `tdo_oe` is 0.
- R3: Capture-IR loads binary 01 into the instruction shift stage. It leaves LSB first, so the first two bits seen on `tdo` during Shift-IR are 1 then 0.
- R4: `tdo_oe` is 1 only while the controller is in Shift-IR or Shift-DR, and `tdo` and `tdo_oe` change only on the falling edge of `tck`.
- R5: `tdi` is sampled on the rising edge of `tck` in a shift state, including the edge that leaves the shift state. N rising edges spent in Shift-DR therefore move exactly N bits in and N bits out.
- R6: Instruction codes: 00 selects external test, 01 selects sample/preload, 11 selects BYPASS, and 10 behaves as BYPASS. The BYPASS register is 1 bit, captures 0, and delays `tdi` by one shift. A new instruction takes effect only at Update-IR.
- R7: The boundary chain is 22 bits. Bit 0 is nearest `tdo` and `tdi` enters at bit 21. Bits 7:0 are write data, 15:8 read data, 19:16 address, 20 output enable and 21 write enable. Capture-DR loads `core_wdata`, `mem_rdata`, `core_addr`, `core_oe_n` and `core_we_n` into those positions.
- R8: Under external test the SRAM-side outputs and `core_rdata` show the update-stage values from the R7 positions. Under sample/preload the pins stay in pass-through while the update stage still loads, so a later switch to external test drives the preloaded values.
- R9: The capture/shift stage changes only in Capture-DR or Shift-DR. The update stage changes only on the falling edge in Update-DR. A shift that pauses through Exit1-DR and Pause-DR leaves the pins unchanged until Update-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset of the test logic |
| tms | input | 1 | Controller mode select, sampled on rising edge |
| tdi | input | 1 | Serial test data in, sampled on rising edge |
| tdo | output | 1 | Serial test data out, changes on falling edge |
| tdo_oe | output | 1 | High while `tdo` carries data, low when released |
| core_wdata | input | 8 | Write data from the core toward the SRAM |
| core_addr | input | 4 | Address from the core |
| core_oe_n | input | 1 | Output enable (active low) from the core |
| core_we_n | input | 1 | Write enable (active low) from the core |
| core_rdata | output | 8 | Read data toward the core |
| mem_wdata | output | 8 | Write data to the SRAM pins |
| mem_addr | output | 4 | Address to the SRAM pins |
| mem_oe_n | output | 1 | Output enable to the SRAM |
| mem_we_n | output | 1 | Write enable to the SRAM |
| mem_rdata | input | 8 | Read data from the SRAM pins |

## Verification
The bound checker watches, on every rising edge, several cycle-local rules. The five-ones return to reset, the 01 capture pattern, and an output enable that is never raised outside a shift state are among them. It also checks that the boundary and instruction registers move only in their permitted controller states and that the pins are in pass-through whenever external test is not active. Whether a full 22-bit pattern arrives in the right cell positions, whether the bypass delay is exactly one bit, and whether a preload survives an instruction change are end-to-end sequences. Only the bench's scenarios can show those, by shifting patterns in and comparing what comes out on `tdo` and on the pins.

// File: rtl/bsw_pkg.sv
`timescale 1ns/1ps
package bsw_pkg;

    typedef enum logic [3:0] {
        TS_RESET,
        TS_IDLE,
        TS_SEL_DR,
        TS_CAP_DR,
        TS_SHF_DR,
        TS_EX1_DR,
        TS_PAU_DR,
        TS_EX2_DR,
        TS_UPD_DR,
        TS_SEL_IR,
        TS_CAP_IR,
        TS_SHF_IR,
        TS_EX1_IR,
        TS_PAU_IR,
        TS_EX2_IR,
        TS_UPD_IR
    } tap_state_e;

    localparam int IR_W = 2;

    typedef enum logic [IR_W-1:0] {
        OP_EXTEST = 2'b00,
        OP_SAMPLE = 2'b01,
        OP_RSVD   = 2'b10,
        OP_BYPASS = 2'b11
    } opcode_e;

    localparam logic [IR_W-1:0] IR_CAPTURE = 2'b01;

    typedef struct packed {
        logic use_bsr;     // boundary chain is the selected data register
        logic drive_pins;  // update stage drives the pins
    } op_ctl_t;

    function automatic op_ctl_t op_decode(opcode_e op);
        op_ctl_t c;
        case (op)
            OP_EXTEST: c = '{use_bsr: 1'b1, drive_pins: 1'b1};
            OP_SAMPLE: c = '{use_bsr: 1'b1, drive_pins: 1'b0};
            default:   c = '{use_bsr: 1'b0, drive_pins: 1'b0};
        endcase
        return c;
    endfunction

    function automatic tap_state_e tap_next(tap_state_e s, logic tms);
        tap_state_e n;
        case (s)
            TS_RESET:  n = tms ? TS_RESET  : TS_IDLE;
            TS_IDLE:   n = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR: n = tms ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: n = tms ? TS_EX1_DR : TS_SHF_DR;
            TS_SHF_DR: n = tms ? TS_EX1_DR : TS_SHF_DR;
            TS_EX1_DR: n = tms ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: n = tms ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: n = tms ? TS_UPD_DR : TS_SHF_DR;
            TS_UPD_DR: n = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR: n = tms ? TS_RESET  : TS_CAP_IR;
            TS_CAP_IR: n = tms ? TS_EX1_IR : TS_SHF_IR;
            TS_SHF_IR: n = tms ? TS_EX1_IR : TS_SHF_IR;
            TS_EX1_IR: n = tms ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: n = tms ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: n = tms ? TS_UPD_IR : TS_SHF_IR;
            TS_UPD_IR: n = tms ? TS_SEL_DR : TS_IDLE;
            default:   n = TS_RESET;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/bsw_tap_fsm.sv
`timescale 1ns/1ps
module bsw_tap_fsm
    import bsw_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state
);

    always_ff @(posedge tck) begin
        if (rst) state <= TS_RESET;
        else     state <= tap_next(state, tms);
    end

endmodule

// File: rtl/bsw_ir.sv
`timescale 1ns/1ps
module bsw_ir
    import bsw_pkg::*;
(
    input  logic            tck,
    input  logic            rst,
    input  logic            tdi,
    input  tap_state_e      state,
    output opcode_e         ir_q,
    output logic [IR_W-1:0] ir_sr
);

    // capture/shift stage on the rising edge
    always_ff @(posedge tck) begin
        if (rst)                    ir_sr <= '0;
        else if (state == TS_CAP_IR) ir_sr <= IR_CAPTURE;
        else if (state == TS_SHF_IR) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    // instruction latch on the falling edge, forced to bypass in reset state
    always_ff @(negedge tck) begin
        if (rst || state == TS_RESET) ir_q <= OP_BYPASS;
        else if (state == TS_UPD_IR)  ir_q <= opcode_e'(ir_sr);
    end

endmodule

// File: rtl/bsw_bscell.sv
`timescale 1ns/1ps
module bsw_bscell (
    input  logic tck,
    input  logic rst,
    input  logic cap_en,
    input  logic shf_en,
    input  logic upd_en,
    input  logic mode,
    input  logic func_in,
    input  logic scan_in,
    output logic scan_q,
    output logic upd_q,
    output logic pin_out
);

    always_ff @(posedge tck) begin
        if (rst)         scan_q <= 1'b0;
        else if (cap_en) scan_q <= func_in;
        else if (shf_en) scan_q <= scan_in;
    end

    always_ff @(negedge tck) begin
        if (rst)         upd_q <= 1'b0;
        else if (upd_en) upd_q <= scan_q;
    end

    assign pin_out = mode ? upd_q : func_in;

endmodule

// File: rtl/bsw_bscan_chain.sv
`timescale 1ns/1ps
module bsw_bscan_chain #(
    parameter int LEN = 22
) (
    input  logic           tck,
    input  logic           rst,
    input  logic           cap_en,
    input  logic           shf_en,
    input  logic           upd_en,
    input  logic           mode,
    input  logic           tdi,
    input  logic [LEN-1:0] func_in,
    output logic [LEN-1:0] pin_out,
    output logic [LEN-1:0] scan_q,
    output logic [LEN-1:0] upd_q
);

    for (genvar i = 0; i < LEN; i++) begin : g_cell
        logic sin;
        if (i == LEN - 1) begin : g_head
            assign sin = tdi;
        end else begin : g_link
            assign sin = scan_q[i+1];
        end
        bsw_bscell u_cell (
            .tck     (tck),
            .rst     (rst),
            .cap_en  (cap_en),
            .shf_en  (shf_en),
            .upd_en  (upd_en),
            .mode    (mode),
            .func_in (func_in[i]),
            .scan_in (sin),
            .scan_q  (scan_q[i]),
            .upd_q   (upd_q[i]),
            .pin_out (pin_out[i])
        );
    end

endmodule

// File: rtl/bsw_sram_wrap.sv
`timescale 1ns/1ps
module bsw_sram_wrap
    import bsw_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              tck,
    input  logic              rst,
    input  logic              tms,
    input  logic              tdi,
    output logic              tdo,
    output logic              tdo_oe,
    input  logic [DATA_W-1:0] core_wdata,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic              core_oe_n,
    input  logic              core_we_n,
    output logic [DATA_W-1:0] core_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int OFF_RD    = DATA_W;
    localparam int OFF_AD    = 2 * DATA_W;
    localparam int OFF_OE    = OFF_AD + ADDR_W;
    localparam int OFF_WE    = OFF_OE + 1;
    localparam int CHAIN_LEN = OFF_WE + 1;

    tap_state_e            state;
    opcode_e               ir_q;
    logic [IR_W-1:0]       ir_sr;
    op_ctl_t               ctl;
    logic [CHAIN_LEN-1:0]  func_vec;
    logic [CHAIN_LEN-1:0]  pin_vec;
    logic [CHAIN_LEN-1:0]  bsr_q;
    logic [CHAIN_LEN-1:0]  bsr_u;
    logic                  byp_q;
    logic                  in_cap_dr, in_shf_dr, in_upd_dr, in_shf_ir;
    logic                  dr_lsb;

    bsw_tap_fsm u_fsm (
        .tck   (tck),
        .rst   (rst),
        .tms   (tms),
        .state (state)
    );

    bsw_ir u_ir (
        .tck   (tck),
        .rst   (rst),
        .tdi   (tdi),
        .state (state),
        .ir_q  (ir_q),
        .ir_sr (ir_sr)
    );

    always_comb begin
        ctl       = op_decode(ir_q);
        in_cap_dr = (state == TS_CAP_DR);
        in_shf_dr = (state == TS_SHF_DR);
        in_upd_dr = (state == TS_UPD_DR);
        in_shf_ir = (state == TS_SHF_IR);
    end

    assign func_vec = {core_we_n, core_oe_n, core_addr, mem_rdata, core_wdata};

    bsw_bscan_chain #(.LEN(CHAIN_LEN)) u_chain (
        .tck     (tck),
        .rst     (rst),
        .cap_en  (ctl.use_bsr && in_cap_dr),
        .shf_en  (ctl.use_bsr && in_shf_dr),
        .upd_en  (ctl.use_bsr && in_upd_dr),
        .mode    (ctl.drive_pins),
        .tdi     (tdi),
        .func_in (func_vec),
        .pin_out (pin_vec),
        .scan_q  (bsr_q),
        .upd_q   (bsr_u)
    );

    assign mem_wdata  = pin_vec[OFF_RD-1:0];
    assign core_rdata = pin_vec[OFF_AD-1:OFF_RD];
    assign mem_addr   = pin_vec[OFF_OE-1:OFF_AD];
    assign mem_oe_n   = pin_vec[OFF_OE];
    assign mem_we_n   = pin_vec[OFF_WE];

    // single-bit bypass register
    always_ff @(posedge tck) begin
        if (rst)                              byp_q <= 1'b0;
        else if (!ctl.use_bsr && in_cap_dr)   byp_q <= 1'b0;
        else if (!ctl.use_bsr && in_shf_dr)   byp_q <= tdi;
    end

    assign dr_lsb = ctl.use_bsr ? bsr_q[0] : byp_q;

    // serial output retimed to the falling edge
    always_ff @(negedge tck) begin
        if (rst) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= in_shf_ir || in_shf_dr;
            tdo    <= in_shf_ir ? ir_sr[0] : (in_shf_dr ? dr_lsb : 1'b0);
        end
    end

endmodule

// File: rtl/bsw_checker.sv
`timescale 1ns/1ps
module bsw_checker
    import bsw_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input logic                         tck,
    input logic                         rst,
    input logic                         tms,
    input tap_state_e                   state,
    input opcode_e                      ir_q,
    input logic [IR_W-1:0]              ir_sr,
    input logic [2*DATA_W+ADDR_W+1:0]   bsr_q,
    input logic [2*DATA_W+ADDR_W+1:0]   bsr_u,
    input logic                         tdo_oe,
    input logic [ADDR_W-1:0]            core_addr,
    input logic [ADDR_W-1:0]            mem_addr,
    input logic [DATA_W-1:0]            core_wdata,
    input logic [DATA_W-1:0]            mem_wdata
);

    logic [2:0] ones_cnt;

    always_ff @(posedge tck) begin
        if (rst)                 ones_cnt <= '0;
        else if (!tms)           ones_cnt <= '0;
        else if (ones_cnt != 5)  ones_cnt <= ones_cnt + 3'd1;
    end

    p_five_ones_r2: assert property (@(posedge tck) disable iff (rst)
        (ones_cnt == 3'd5) |-> (state == TS_RESET));

    p_reset_bypass_r1: assert property (@(posedge tck) disable iff (rst)
        (state == TS_RESET) |-> (ir_q == OP_BYPASS));

    p_ir_capture_r3: assert property (@(posedge tck) disable iff (rst)
        (state == TS_CAP_IR) |=> (ir_sr == IR_CAPTURE));

    p_oe_in_shift_r4: assert property (@(posedge tck) disable iff (rst)
        tdo_oe |-> (state == TS_SHF_IR || state == TS_SHF_DR));

    p_ir_change_r6: assert property (@(posedge tck) disable iff (rst)
        !$stable(ir_q) |-> (state == TS_UPD_IR || state == TS_RESET));

    p_pass_through_r8: assert property (@(posedge tck) disable iff (rst)
        (ir_q != OP_EXTEST) |-> (mem_addr == core_addr && mem_wdata == core_wdata));

    p_scan_hold_r9: assert property (@(posedge tck) disable iff (rst)
        !(state == TS_CAP_DR || state == TS_SHF_DR) |=> $stable(bsr_q));

    p_update_only_r9: assert property (@(posedge tck) disable iff (rst)
        !$stable(bsr_u) |-> (state == TS_UPD_DR));

endmodule

bind bsw_sram_wrap bsw_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .tck        (tck),
    .rst        (rst),
    .tms        (tms),
    .state      (state),
    .ir_q       (ir_q),
    .ir_sr      (ir_sr),
    .bsr_q      (bsr_q),
    .bsr_u      (bsr_u),
    .tdo_oe     (tdo_oe),
    .core_addr  (core_addr),
    .mem_addr   (mem_addr),
    .core_wdata (core_wdata),
    .mem_wdata  (mem_wdata)
);

// File: tb/sim_bsw_sram_wrap.sv
`timescale 1ns/1ps
module sim_bsw_sram_wrap;

    logic       tck = 1'b0;
    logic       rst = 1'b1;
    logic       tms = 1'b1;
    logic       tdi = 1'b0;
    logic       tdo, tdo_oe;
    logic [7:0] core_wdata = 8'h3C;
    logic [3:0] core_addr  = 4'hA;
    logic       core_oe_n  = 1'b0;
    logic       core_we_n  = 1'b1;
    logic [7:0] core_rdata, mem_wdata;
    logic [3:0] mem_addr;
    logic       mem_oe_n, mem_we_n;
    logic [7:0] mem_rdata  = 8'h77;

    int n_chk = 0;
    int n_err = 0;

    always #4 tck = ~tck;

    bsw_sram_wrap u0 (
        .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
        .core_wdata(core_wdata), .core_addr(core_addr), .core_oe_n(core_oe_n),
        .core_we_n(core_we_n), .core_rdata(core_rdata), .mem_wdata(mem_wdata),
        .mem_addr(mem_addr), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_rdata(mem_rdata)
    );

    // scan value [43:22], core_wdata [21:14], core_addr [13:10],
    // {we_n, oe_n} [9:8], mem_rdata [7:0]
    localparam logic [43:0] VEC [6] = '{
        {22'h000001, 8'hA5, 4'h3, 2'b01, 8'h5A},
        {22'h200000, 8'h01, 4'h8, 2'b10, 8'h80},
        {22'h3FFFFF, 8'h00, 4'h0, 2'b00, 8'h00},
        {22'h155555, 8'hFF, 4'hF, 2'b11, 8'hFF},
        {22'h2AAAAA, 8'h3C, 4'h6, 2'b10, 8'hC3},
        {22'h0F0F0F, 8'h96, 4'h9, 2'b01, 8'h69}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [21:0] func_now();
        return {core_we_n, core_oe_n, core_addr, mem_rdata, core_wdata};
    endfunction

    function automatic logic [21:0] pins_now();
        return {mem_we_n, mem_oe_n, mem_addr, core_rdata, mem_wdata};
    endfunction

    task automatic tick(input logic m, input logic d, output logic o, output logic e);
        @(negedge tck);
        #1;
        o = tdo;
        e = tdo_oe;
        tms = m;
        tdi = d;
    endtask

    // starts and ends in Run-Test/Idle
    task automatic shift_dr(input int n, input logic [31:0] din,
                            output logic [31:0] dout, output logic oe_all);
        logic o, e;
        dout = '0;
        oe_all = 1'b1;
        tick(1'b1, 1'b0, o, e);
        tick(1'b0, 1'b0, o, e);
        tick(1'b0, 1'b0, o, e);
        for (int i = 0; i < n; i++) begin
            tick(i == n - 1, din[i], o, e);
            dout[i] = o;
            oe_all = oe_all & e;
        end
        tick(1'b1, 1'b0, o, e);
        tick(1'b0, 1'b0, o, e);
    endtask

    task automatic shift_ir(input logic [1:0] din, output logic [1:0] dout);
        logic o, e;
        tick(1'b1, 1'b0, o, e);
        tick(1'b1, 1'b0, o, e);
        tick(1'b0, 1'b0, o, e);
        tick(1'b0, 1'b0, o, e);
        tick(1'b0, din[0], o, e);
        dout[0] = o;
        tick(1'b1, din[1], o, e);
        dout[1] = o;
        tick(1'b1, 1'b0, o, e);
        tick(1'b0, 1'b0, o, e);
    endtask

    initial begin
        #(200_000 * 8);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: run did not complete");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic        o, e, oe_all;
        logic [1:0]  irout;
        logic [31:0] dout;
        logic [21:0] pat;

        repeat (3) @(negedge tck);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk("R1 tdo_oe after reset", {63'd0, tdo_oe}, 64'd0);
        chk("R1 pins pass-through", {42'd0, pins_now()}, {42'd0, func_now()});

        tick(1'b0, 1'b0, o, e);   // to Run-Test/Idle
        tick(1'b0, 1'b0, o, e);
        chk("R4 tdo_oe low in idle", {63'd0, e}, 64'd0);

        // R3: capture pattern while loading BYPASS
        shift_ir(2'b11, irout);
        chk("R3 IR capture value", {62'd0, irout}, 64'd1);

        // R6: bypass one-bit delay, captures 0
        shift_dr(4, 32'b1011, dout, oe_all);
        chk("R6 bypass delay", dout, 64'b0110);
        chk("R4 tdo_oe during Shift-DR", {63'd0, oe_all}, 64'd1);

        // R6: reserved code behaves as bypass
        shift_ir(2'b10, irout);
        shift_dr(3, 32'b101, dout, oe_all);
        chk("R6 reserved code as bypass", dout, 64'b010);

        // R7/R8: sample/preload
        shift_ir(2'b01, irout);
        pat = 22'h2B4C6D;
        shift_dr(22, {10'd0, pat}, dout, oe_all);
        chk("R7 sample capture", dout, {42'd0, func_now()});
        chk("R8 sample keeps pass-through", {42'd0, pins_now()}, {42'd0, func_now()});

        shift_ir(2'b00, irout);
        chk("R8 preload driven under external test", {42'd0, pins_now()}, {42'd0, pat});

        // R5/R7/R8: vector table under external test
        foreach (VEC[k]) begin
            core_wdata = VEC[k][21:14];
            core_addr  = VEC[k][13:10];
            core_we_n  = VEC[k][9];
            core_oe_n  = VEC[k][8];
            mem_rdata  = VEC[k][7:0];
            shift_dr(22, {10'd0, VEC[k][43:22]}, dout, oe_all);
            chk("R7 capture order", dout,
                {42'd0, VEC[k][9], VEC[k][8], VEC[k][13:10], VEC[k][7:0], VEC[k][21:14]});
            chk("R5 R8 pins show shifted pattern", {42'd0, pins_now()}, {42'd0, VEC[k][43:22]});
        end

        // R9: shift then pause, pins hold until Update-DR
        pat = 22'h1C3A5E;
        tick(1'b1, 1'b0, o, e);
        tick(1'b0, 1'b0, o, e);
        tick(1'b0, 1'b0, o, e);
        for (int i = 0; i < 22; i++) tick(i == 21, pat[i], o, e);
        tick(1'b0, 1'b0, o, e);   // Exit1 -> Pause
        tick(1'b0, 1'b0, o, e);
        chk("R9 pins hold while paused", {42'd0, pins_now()}, {42'd0, VEC[5][43:22]});
        tick(1'b1, 1'b0, o, e);   // Exit2
        tick(1'b1, 1'b0, o, e);   // Update-DR
        tick(1'b0, 1'b0, o, e);
        chk("R9 pins updated at Update-DR", {42'd0, pins_now()}, {42'd0, pat});

        // R2: five TMS-high edges from inside Shift-DR
        tick(1'b1, 1'b0, o, e);
        tick(1'b0, 1'b0, o, e);
        tick(1'b0, 1'b0, o, e);
        tick(1'b0, 1'b1, o, e);
        tick(1'b0, 1'b0, o, e);
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, o, e);
        tick(1'b0, 1'b0, o, e);
        chk("R2 released output after five ones", {63'd0, e}, 64'd0);
        chk("R2 pass-through restored", {42'd0, pins_now()}, {42'd0, func_now()});

        shift_dr(2, 32'b11, dout, oe_all);
        chk("R2 bypass active after reset", dout, 64'b10);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule